// File: doc/BRIEF.md
# Shared Low/High-Pass Parallel FIR Stage

This block is one filtering level of a linearized wavelet packet decomposition. On every clock it can take a block of P consecutive samples, with lane 0 holding the oldest. It returns a block of P filtered results. Results at even stream positions are low-pass outputs and results at odd positions are high-pass outputs. A later stage can therefore decimate by picking lanes. Only one multiplier array is used. Each product's coefficient comes from the low or high set according to the parity of the output position it feeds.

The arithmetic is block-transposed. Each input sample is multiplied by every tap once. A product whose output position falls in the current block is summed into that lane. A product that belongs to a later block is kept in a register of pending partial sums. This means raw past samples are never stored. The run-time coefficient sets are written into a staging copy one tap at a time. The filter switches to the new sets only on a commit strobe.

Top module: `lp_hp_fir`

## Requirements
- R1: Every valid input block yields exactly one valid output block. If `valid_i` is high before clock edge t, `valid_o` is high after edge t+2. Back-to-back input blocks give back-to-back output blocks with no stall cycle.
- R2: Let stream position m = nP + j. Output lane j gives y[m] = sum over k of c[k]*x[m-k], with k = 0..TAPS-1. The c set is the low-pass set (select 0) for even j and the high-pass set (select 1) for odd j. When `valid_o` is high, `hi_o[j]` equals 1 exactly for odd j.
- R3: Samples x[m-k] from earlier valid blocks take part in later outputs. A cycle with `valid_i` low does not advance that history, whatever `data_i` holds.
- R4: A write (`coef_we_i`) with address = tap index k and select (0 low, 1 high) goes only to a staging copy and does not change outputs. `coef_commit_i` copies the whole staging copy to the active sets. When a write and a commit fall on the same edge, the commit takes the staging values as they were before that write.
- R5: Coefficients are signed with FRAC = CW-1 fractional bits. The result is floor((sum + 2^(FRAC-1)) / 2^FRAC), which rounds to nearest with ties toward plus infinity.
- R6: Rounded results outside the signed DW-bit range are clamped to 2^(DW-1)-1 or -2^(DW-1).
- R7: After reset, all coefficients, pending sums and outputs are zero and `valid_o` is low. Blocks that enter before any commit produce valid zero results.
- R8: While `valid_o` is low, `data_o` and `hi_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input block valid |
| data_i | input | P*DW | P signed samples, lane 0 oldest at LSB |
| coef_we_i | input | 1 | Staging coefficient write |
| coef_sel_i | input | 1 | 0 low-pass set, 1 high-pass set |
| coef_addr_i | input | CAW | Tap index |
| coef_data_i | input | CW | Signed coefficient value |
| coef_commit_i | input | 1 | Copy staging sets to active sets |
| valid_o | output | 1 | Output block valid |
| data_o | output | P*DW | P rounded, saturated results |
| hi_o | output | P | Per-lane high-pass tag |

## Verification
The hardest case to reach is the boundary of the staging and commit scheme. A pending sum built with the old set must not reach a check made against the new set. The write that coincides with a commit must also stay hidden until the following commit. Before each coefficient change, the stimulus streams an all-zero block, which empties the pending sums. It then stages writes and checks that outputs keep the old response. It commits once with a same-edge write and then once more. Invalid gap blocks carry full-scale garbage, so any history advance during a gap shows up in the next valid block.

// File: rtl/lp_hp_fir_pkg.sv
package lp_hp_fir_pkg;
  typedef enum logic {
    SET_LO = 1'b0,
    SET_HI = 1'b1
  } coef_set_e;
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank
  import lp_hp_fir_pkg::*;
#(
  parameter int TAPS = 4,
  parameter int CW   = 12,
  parameter int AW   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [CW-1:0]      data_i,
  input  logic               commit_i,
  output logic [TAPS*CW-1:0] lo_o,
  output logic [TAPS*CW-1:0] hi_o
);
  logic [TAPS*CW-1:0] stg_lo_q, stg_hi_q, act_lo_q, act_hi_q;
  logic               addr_ok;

  assign addr_ok = int'(addr_i) < TAPS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_lo_q <= '0;
      stg_hi_q <= '0;
      act_lo_q <= '0;
      act_hi_q <= '0;
    end else begin
      // commit sees staging before this edge's write
      if (commit_i) begin
        act_lo_q <= stg_lo_q;
        act_hi_q <= stg_hi_q;
      end
      if (we_i && addr_ok) begin
        if (coef_set_e'(sel_i) == SET_HI) stg_hi_q[int'(addr_i)*CW +: CW] <= data_i;
        else                              stg_lo_q[int'(addr_i)*CW +: CW] <= data_i;
      end
    end
  end

  assign lo_o = act_lo_q;
  assign hi_o = act_hi_q;
endmodule

// File: rtl/fir_block_mac.sv
module fir_block_mac #(
  parameter int P    = 4,
  parameter int TAPS = 4,
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter int ACCW = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [P*DW-1:0]    smp_i,
  input  logic [TAPS*CW-1:0] coef_lo_i,
  input  logic [TAPS*CW-1:0] coef_hi_i,
  output logic               vld_o,
  output logic [P*ACCW-1:0]  sum_o
);
  localparam int PW    = DW + CW;
  localparam int NPOS  = P + TAPS - 1;
  localparam int NPEND = TAPS - 1;

  logic signed [PW-1:0]   prod   [P][TAPS];
  logic signed [ACCW-1:0] acc    [NPOS];
  logic signed [ACCW-1:0] pend_q [NPEND];
  logic signed [ACCW-1:0] sum_q  [P];
  logic                   vld_q;

  // one product per (sample lane, tap); set chosen by parity of target position
  for (genvar j = 0; j < P; j++) begin : g_lane
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      localparam bit ODD = ((j + k) % 2) == 1;
      logic signed [DW-1:0] xs;
      logic signed [CW-1:0] cs;
      assign xs = smp_i[j*DW +: DW];
      if (ODD) begin : g_hi
        assign cs = coef_hi_i[k*CW +: CW];
      end else begin : g_lo
        assign cs = coef_lo_i[k*CW +: CW];
      end
      assign prod[j][k] = PW'(xs) * PW'(cs);
    end
  end

  always_comb begin
    for (int q = 0; q < NPOS; q++) acc[q] = '0;
    for (int f = 0; f < NPEND; f++) acc[f] = pend_q[f];
    for (int j = 0; j < P; j++) begin
      for (int k = 0; k < TAPS; k++) begin
        acc[j+k] = acc[j+k] + ACCW'(prod[j][k]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      for (int l = 0; l < P; l++) sum_q[l] <= '0;
      for (int f = 0; f < NPEND; f++) pend_q[f] <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        for (int l = 0; l < P; l++) sum_q[l] <= acc[l];
        for (int f = 0; f < NPEND; f++) pend_q[f] <= acc[P+f];
      end
    end
  end

  for (genvar l = 0; l < P; l++) begin : g_out
    assign sum_o[l*ACCW +: ACCW] = sum_q[l];
  end
  assign vld_o = vld_q;
endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
  parameter int ACCW = 26,
  parameter int FRAC = 11,
  parameter int DW   = 12
) (
  input  logic [ACCW-1:0] acc_i,
  output logic [DW-1:0]   res_o
);
  localparam logic signed [ACCW:0] HALF = (ACCW+1)'(1) <<< (FRAC - 1);
  localparam logic signed [ACCW:0] MAXV = (ACCW+1)'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [ACCW:0] MINV = ~MAXV;

  logic signed [ACCW:0] biased, shifted;

  always_comb begin
    biased  = $signed({acc_i[ACCW-1], acc_i}) + HALF;
    shifted = biased >>> FRAC;
    if (shifted > MAXV)      res_o = {1'b0, {(DW-1){1'b1}}};
    else if (shifted < MINV) res_o = {1'b1, {(DW-1){1'b0}}};
    else                     res_o = shifted[DW-1:0];
  end
endmodule

// File: rtl/lp_hp_fir.sv
module lp_hp_fir #(
  parameter int P    = 4,              // power of two, >= 2
  parameter int TAPS = 4,              // >= 2
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter int FRAC = CW - 1,
  parameter int CAW  = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [P*DW-1:0]   data_i,
  input  logic              coef_we_i,
  input  logic              coef_sel_i,
  input  logic [CAW-1:0]    coef_addr_i,
  input  logic [CW-1:0]     coef_data_i,
  input  logic              coef_commit_i,
  output logic              valid_o,
  output logic [P*DW-1:0]   data_o,
  output logic [P-1:0]      hi_o
);
  localparam int ACCW = DW + CW + $clog2(TAPS);

  logic              in_vld_q;
  logic [P*DW-1:0]   in_smp_q;
  logic [TAPS*CW-1:0] coef_lo_act, coef_hi_act;
  logic              sum_vld;
  logic [P*ACCW-1:0] sum_flat;
  logic [P*DW-1:0]   rs_flat;
  logic [P-1:0]      odd_mask;
  logic              out_vld_q;
  logic [P*DW-1:0]   out_data_q;
  logic [P-1:0]      out_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_vld_q <= 1'b0;
      in_smp_q <= '0;
    end else begin
      in_vld_q <= valid_i;
      if (valid_i) in_smp_q <= data_i;
    end
  end

  fir_coef_bank #(.TAPS(TAPS), .CW(CW), .AW(CAW)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (coef_we_i),
    .sel_i    (coef_sel_i),
    .addr_i   (coef_addr_i),
    .data_i   (coef_data_i),
    .commit_i (coef_commit_i),
    .lo_o     (coef_lo_act),
    .hi_o     (coef_hi_act)
  );

  fir_block_mac #(.P(P), .TAPS(TAPS), .DW(DW), .CW(CW), .ACCW(ACCW)) u_mac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (in_vld_q),
    .smp_i     (in_smp_q),
    .coef_lo_i (coef_lo_act),
    .coef_hi_i (coef_hi_act),
    .vld_o     (sum_vld),
    .sum_o     (sum_flat)
  );

  for (genvar l = 0; l < P; l++) begin : g_rs
    fir_round_sat #(.ACCW(ACCW), .FRAC(FRAC), .DW(DW)) u_rs (
      .acc_i (sum_flat[l*ACCW +: ACCW]),
      .res_o (rs_flat[l*DW +: DW])
    );
    assign odd_mask[l] = (l % 2) == 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
      out_hi_q   <= '0;
    end else begin
      out_vld_q  <= sum_vld;
      out_data_q <= sum_vld ? rs_flat : '0;
      out_hi_q   <= sum_vld ? odd_mask : '0;
    end
  end

  assign valid_o = out_vld_q;
  assign data_o  = out_data_q;
  assign hi_o    = out_hi_q;
endmodule

// File: rtl/lp_hp_fir_chk.sv
module lp_hp_fir_chk #(
  parameter int P    = 4,
  parameter int TAPS = 4,
  parameter int DW   = 12,
  parameter int CW   = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               valid_o,
  input logic [P*DW-1:0]    data_o,
  input logic [P-1:0]       hi_o,
  input logic               coef_commit_i,
  input logic [TAPS*CW-1:0] coef_lo_act,
  input logic [TAPS*CW-1:0] coef_hi_act
);
  logic [1:0]   age_q;
  logic [P-1:0] exp_tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  always_comb begin
    for (int l = 0; l < P; l++) exp_tag[l] = (l % 2) == 1;
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  assert_lane_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (hi_o == exp_tag));

  assert_hold_until_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q != 2'd0) && !$past(coef_commit_i)) |-> ($stable(coef_lo_act) && $stable(coef_hi_act)));

  assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ((data_o == '0) && (hi_o == '0)));
endmodule

bind lp_hp_fir lp_hp_fir_chk #(.P(P), .TAPS(TAPS), .DW(DW), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .valid_o       (valid_o),
  .data_o        (data_o),
  .hi_o          (hi_o),
  .coef_commit_i (coef_commit_i),
  .coef_lo_act   (coef_lo_act),
  .coef_hi_act   (coef_hi_act)
);

// File: tb/lp_hp_fir_tb.sv
module lp_hp_fir_tb;
  localparam int P    = 4;
  localparam int TAPS = 4;
  localparam int DW   = 12;
  localparam int CW   = 12;
  localparam int FRAC = CW - 1;
  localparam int CAW  = $clog2(TAPS);
  localparam int NST  = 10;

  // {valid, lane3, lane2, lane1, lane0}
  localparam logic [P*DW:0] STIM [NST] = '{
    {1'b1, 12'h004, 12'h003, 12'h002, 12'h001},
    {1'b1, 12'h010, 12'hFF0, 12'h020, 12'hFE0},
    {1'b0, 12'h7FF, 12'h7FF, 12'h7FF, 12'h7FF},
    {1'b1, 12'h100, 12'h080, 12'h040, 12'h020},
    {1'b1, 12'hF00, 12'h100, 12'hF00, 12'h100},
    {1'b0, 12'h123, 12'h456, 12'h789, 12'hABC},
    {1'b0, 12'h800, 12'h800, 12'h800, 12'h800},
    {1'b1, 12'h3FF, 12'hC01, 12'h000, 12'h555},
    {1'b1, 12'h001, 12'h001, 12'h001, 12'h001},
    {1'b1, 12'h7FF, 12'h800, 12'h7FF, 12'h800}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_ni;
  logic            valid_i;
  logic [P*DW-1:0] data_i;
  logic            coef_we_i, coef_sel_i, coef_commit_i;
  logic [CAW-1:0]  coef_addr_i;
  logic [CW-1:0]   coef_data_i;
  logic            valid_o;
  logic [P*DW-1:0] data_o;
  logic [P-1:0]    hi_o;

  lp_hp_fir #(.P(P), .TAPS(TAPS), .DW(DW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .coef_we_i(coef_we_i), .coef_sel_i(coef_sel_i), .coef_addr_i(coef_addr_i),
    .coef_data_i(coef_data_i), .coef_commit_i(coef_commit_i),
    .valid_o(valid_o), .data_o(data_o), .hi_o(hi_o)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int act_lo [TAPS], act_hi [TAPS], stg_lo [TAPS], stg_hi [TAPS];
  int past [TAPS-1];

  bit    s_v   [3];
  int    s_d   [3][P];
  string s_tag [3];

  function automatic logic [P-1:0] odd_m();
    logic [P-1:0] m;
    for (int j = 0; j < P; j++) m[j] = (j % 2) == 1;
    return m;
  endfunction

  task automatic model_beat(input logic [P*DW-1:0] d);
    int full [P+TAPS-1];
    for (int i = 0; i < TAPS-1; i++) full[i] = past[TAPS-2-i];
    for (int j = 0; j < P; j++) full[TAPS-1+j] = int'($signed(d[j*DW +: DW]));
    for (int j = 0; j < P; j++) begin
      longint s = 0;
      longint r;
      for (int k = 0; k < TAPS; k++) begin
        longint c = (j % 2 == 1) ? longint'(act_hi[k]) : longint'(act_lo[k]);
        s += c * longint'(full[TAPS-1+j-k]);
      end
      r = (s + (longint'(1) <<< (FRAC-1))) >>> FRAC;
      if (r > ((longint'(1) <<< (DW-1)) - 1)) r = (longint'(1) <<< (DW-1)) - 1;
      if (r < -(longint'(1) <<< (DW-1)))      r = -(longint'(1) <<< (DW-1));
      s_d[0][j] = int'(r);
    end
    for (int i = 0; i < TAPS-1; i++) past[i] = full[P+TAPS-2-i];
  endtask

  task automatic check_out();
    bit bad = 0;
    tests++;
    if (valid_o !== s_v[2]) begin
      bad = 1;
      $display("FAIL %s(R1) valid_o act=%0b exp=%0b", s_tag[2], valid_o, s_v[2]);
    end else if (s_v[2]) begin
      for (int j = 0; j < P; j++) begin
        if (int'($signed(data_o[j*DW +: DW])) != s_d[2][j]) begin
          bad = 1;
          $display("FAIL %s lane %0d act=%0d exp=%0d", s_tag[2], j,
                   int'($signed(data_o[j*DW +: DW])), s_d[2][j]);
        end
      end
      if (hi_o !== odd_m()) begin
        bad = 1;
        $display("FAIL R2 hi_o act=%b exp=%b", hi_o, odd_m());
      end
    end else if (data_o !== '0 || hi_o !== '0) begin
      bad = 1;
      $display("FAIL R8 idle outputs act=%h/%b exp=0/0", data_o, hi_o);
    end
    if (bad) fails++;
  endtask

  task automatic step(input logic v, input logic [P*DW-1:0] d, input string tag);
    check_out();
    s_v[2] = s_v[1]; s_v[1] = s_v[0]; s_v[0] = v;
    s_tag[2] = s_tag[1]; s_tag[1] = s_tag[0]; s_tag[0] = tag;
    for (int j = 0; j < P; j++) begin
      s_d[2][j] = s_d[1][j];
      s_d[1][j] = s_d[0][j];
      s_d[0][j] = 0;
    end
    if (v) model_beat(d);
    valid_i = v;
    data_i  = d;
    @(negedge clk);
  endtask

  task automatic wr_coef(input bit sel, input int addr, input int val, input bit also_commit);
    coef_we_i     = 1'b1;
    coef_sel_i    = sel;
    coef_addr_i   = CAW'(addr);
    coef_data_i   = CW'(val);
    coef_commit_i = also_commit;
    if (also_commit) begin
      for (int k = 0; k < TAPS; k++) begin
        act_lo[k] = stg_lo[k];
        act_hi[k] = stg_hi[k];
      end
    end
    if (sel) stg_hi[addr] = val;
    else     stg_lo[addr] = val;
    step(1'b0, '0, "R4");
    coef_we_i     = 1'b0;
    coef_commit_i = 1'b0;
  endtask

  task automatic commit();
    coef_commit_i = 1'b1;
    for (int k = 0; k < TAPS; k++) begin
      act_lo[k] = stg_lo[k];
      act_hi[k] = stg_hi[k];
    end
    step(1'b0, '0, "R4");
    coef_commit_i = 1'b0;
  endtask

  // zero block empties pending sums before the set changes
  task automatic flush();
    step(1'b1, '0, "R3");
    for (int i = 0; i < 3; i++) step(1'b0, '0, "R8");
  endtask

  task automatic load_set(input int lo [TAPS], input int hi [TAPS]);
    flush();
    for (int k = 0; k < TAPS; k++) begin
      wr_coef(1'b0, k, lo[k], 1'b0);
      wr_coef(1'b1, k, hi[k], 1'b0);
    end
    commit();
    step(1'b0, '0, "R8");
  endtask

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; data_i = '0;
    coef_we_i = 1'b0; coef_sel_i = 1'b0; coef_addr_i = '0;
    coef_data_i = '0; coef_commit_i = 1'b0;
    for (int k = 0; k < TAPS; k++) begin
      act_lo[k] = 0; act_hi[k] = 0; stg_lo[k] = 0; stg_hi[k] = 0;
    end
    for (int i = 0; i < TAPS-1; i++) past[i] = 0;
    for (int s = 0; s < 3; s++) begin
      s_v[s] = 1'b0; s_tag[s] = "R7";
      for (int j = 0; j < P; j++) s_d[s][j] = 0;
    end
    repeat (3) @(negedge clk);
    tests++;
    if (valid_o !== 1'b0 || data_o !== '0 || hi_o !== '0) begin
      fails++;
      $display("FAIL R7 reset act=%b/%h/%b exp=0/0/0", valid_o, data_o, hi_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R7: zero coefficients after reset give valid zeros
    step(1'b1, {4{12'h7FF}}, "R7");
    step(1'b1, {4{12'h800}}, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, '0, "R8");

    // R2/R3: table walk with gaps
    load_set('{512, 1024, 512, 256}, '{256, -512, 1024, -512});
    for (int i = 0; i < NST; i++) begin
      string tg;
      if (!STIM[i][P*DW])                 tg = "R8";
      else if (i > 0 && !STIM[i-1][P*DW]) tg = "R3";
      else                                tg = "R2";
      step(STIM[i][P*DW], STIM[i][P*DW-1:0], tg);
    end
    for (int i = 0; i < 3; i++) step(1'b0, '0, "R8");

    // R4: staged writes stay hidden until commit
    wr_coef(1'b0, 1, -700, 1'b0);
    wr_coef(1'b1, 2, 300, 1'b0);
    step(1'b1, {12'h050, 12'hFB0, 12'h0A0, 12'h030}, "R4");
    step(1'b1, {12'h011, 12'h022, 12'h033, 12'h044}, "R4");
    flush();
    wr_coef(1'b0, 3, 900, 1'b1);  // same-edge write and commit
    step(1'b1, {12'h200, 12'h100, 12'hE00, 12'h300}, "R4");
    step(1'b1, {12'h040, 12'h040, 12'h040, 12'h040}, "R4");
    flush();
    commit();
    step(1'b1, {12'h200, 12'h100, 12'hE00, 12'h300}, "R4");
    step(1'b1, {12'h040, 12'h040, 12'h040, 12'h040}, "R4");

    // R5: half-way cases
    load_set('{1024, 0, 0, 0}, '{-1024, 0, 0, 0});
    step(1'b1, {12'h003, 12'hFFD, 12'hFFF, 12'h001}, "R5");
    step(1'b1, {12'h005, 12'hFFB, 12'h002, 12'hFFE}, "R5");

    // R6: clamp both ways
    load_set('{2047, 2047, 2047, 2047}, '{-2048, -2048, -2048, -2048});
    step(1'b1, {4{12'h7FF}}, "R6");
    step(1'b1, {4{12'h7FF}}, "R6");
    step(1'b1, {4{12'h800}}, "R6");
    step(1'b1, {4{12'h800}}, "R6");
    for (int i = 0; i < 4; i++) step(1'b0, '0, "R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule